// File: doc/BRIEF.md
# Operand Register Redirection and Predicate Lookup

This block sits between instruction decode and the register file read stage. Each instruction carries 5-bit register operand fields; the block looks up every operand in a small table of tag entries and turns it into a 7-bit physical register number in a 128-register space. It also reports whether the operand is to be treated as a vector and which element width override applies. For the destination operand it also looks up a predicate entry, returning the predicate register number and the invert, zeroing and fail-on-first flags that the later element loop needs. Reading the predicate register's contents is left to the stages downstream.

Tag entries and predicate entries are written through two load ports, each accepting either a 16-bit full entry or an 8-bit compact entry. Inside, the tables are kept in expanded form, one slot per register number and register class, so a lookup is a one-hot select of a slot and needs no associative compare. Lookups for rd, rs1 and rs2 happen every cycle and their results are registered.

Top module: `svr_redirect_top`

## Requirements
- R1: While reset is held and in the first cycle after it, every lane output and every predicate output is zero.
- R2: An entry's key is its 5-bit register number (data bits 4:0) together with its class bit (data bit 5, 1 = integer, 0 = floating point); a lookup matches only when both its number and its class bit equal those of a loaded entry.
- R3: A full register entry (wide select high) supplies the target register from data bits 14:8; data bit 15 high makes the operand scalar (vector output low) while still redirecting to that target, and low makes it a vector.
- R4: A compact register entry (wide select low, only data bits 7:0 used) always marks the operand as a vector, with target register equal to the key times four.
- R5: The width output reports the 2-bit override code from data bits 7:6 of the matching register entry (00 default width, 01 8 bits, 10 16 bits, 11 32 bits).
- R6: A full predicate entry gives predicate register from data bits 14:8, invert from bit 6, zeroing from bit 7 and fail-on-first from bit 15; these appear on the predicate outputs with the predicate-active output high when the rd lookup matches it.
- R7: The predicate-active output is high only if rd matches both an active register entry and an active predicate entry; whenever it is low, all other predicate outputs are zero.
- R8: A compact predicate entry (data bits 7:0) takes invert from bit 6 and zeroing from bit 7, sets fail-on-first low, and implies the predicate register key + 9.
- R9: The all-ones output is high exactly when the predicate is active, its register is 0 and its invert flag is set.
- R10: Each lookup result appears on the outputs one clock after the lookup inputs are presented, and reflects the table as it stood before any load accepted in that same cycle.
- R11: A load to a key that already holds an entry of the same kind replaces the old entry, from the next cycle on.
- R12: An operand with no matching active register entry reports vector low, width code 00 and its own 5-bit number zero-extended to 7 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset, clears both tables |
| regLdValid | input | 1 | Write a register tag entry this cycle |
| regLdWide | input | 1 | 1 = full 16-bit entry, 0 = compact 8-bit entry |
| regLdData | input | 16 | Register tag entry contents |
| predLdValid | input | 1 | Write a predicate entry this cycle |
| predLdWide | input | 1 | 1 = full 16-bit entry, 0 = compact 8-bit entry |
| predLdData | input | 16 | Predicate entry contents |
| rdNum | input | 5 | Destination operand number |
| rdIsInt | input | 1 | Destination class, 1 = integer |
| rs1Num | input | 5 | First source operand number |
| rs1IsInt | input | 1 | First source class, 1 = integer |
| rs2Num | input | 5 | Second source operand number |
| rs2IsInt | input | 1 | Second source class, 1 = integer |
| rdVec | output | 1 | Destination is a vector |
| rdReg | output | 7 | Redirected destination register |
| rdWidth | output | 2 | Destination width override code |
| rs1Vec | output | 1 | First source is a vector |
| rs1Reg | output | 7 | Redirected first source register |
| rs1Width | output | 2 | First source width override code |
| rs2Vec | output | 1 | Second source is a vector |
| rs2Reg | output | 7 | Redirected second source register |
| rs2Width | output | 2 | Second source width override code |
| predOn | output | 1 | Destination is predicated |
| predReg | output | 7 | Predicate register number |
| predInv | output | 1 | Invert the mask when used |
| predZero | output | 1 | Zero masked-out elements |
| predFfirst | output | 1 | Fail-on-first mode |
| predAllOnes | output | 1 | Mask is all ones (register 0, inverted) |

## Verification
A table load and a lookup of the very key being loaded can fall in the same cycle, and the result must then show the table from before the load, with the new entry only visible on the following lookup. The bench provokes this with directed cycles that load a register entry while rd, rs1 and rs2 look at that key, and with a random phase that draws loads and lookups from a narrow key range so such collisions recur many times, also for predicate loads against an rd whose register entry is being loaded. Each cycle the behavioural model predicts outputs from its table state before applying that cycle's loads, and every lane and the predicate group are compared.

// File: rtl/svrPkg.sv
package svrPkg;
  localparam int KEY_W  = 5;
  localparam int PHYS_W = 7;
  localparam int EW_W   = 2;
  localparam int IDX_W  = KEY_W + 1;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic              regWr;
    logic [IDX_W-1:0]  regIdx;
    logic              regVec;
    logic [PHYS_W-1:0] regTgt;
    logic [EW_W-1:0]   regEw;
    logic              predWr;
    logic [IDX_W-1:0]  predIdx;
    logic [PHYS_W-1:0] predNum;
    logic              predInv;
    logic              predZero;
    logic              predFf;
  } tblStrobeT;
endpackage

// File: rtl/svrLoadCtl.sv
module svrLoadCtl
  import svrPkg::*;
#(
  parameter int COMPACT_SHIFT = 2,
  parameter int PRED_BASE     = 9
) (
  input  logic              regLdValid,
  input  logic              regLdWide,
  input  logic [DATA_W-1:0] regLdData,
  input  logic              predLdValid,
  input  logic              predLdWide,
  input  logic [DATA_W-1:0] predLdData,
  output tblStrobeT         strobe
);
  // field positions shared by both entry kinds
  localparam int CLASS_BIT  = KEY_W;
  localparam int EW_LO      = KEY_W + 1;
  localparam int INV_BIT    = KEY_W + 1;
  localparam int ZERO_BIT   = KEY_W + 2;
  localparam int TGT_LO     = 8;
  localparam int MODE_BIT   = TGT_LO + PHYS_W;

  logic [PHYS_W-1:0] regKeyWide;
  logic [PHYS_W-1:0] predKeyWide;

  assign regKeyWide  = PHYS_W'(regLdData[KEY_W-1:0]);
  assign predKeyWide = PHYS_W'(predLdData[KEY_W-1:0]);

  always_comb begin
    strobe = '0;
    // register tag entry
    strobe.regWr  = regLdValid;
    strobe.regIdx = {regLdData[CLASS_BIT], regLdData[KEY_W-1:0]};
    strobe.regEw  = regLdData[EW_LO +: EW_W];
    if (regLdWide) begin
      strobe.regVec = ~regLdData[MODE_BIT];
      strobe.regTgt = regLdData[TGT_LO +: PHYS_W];
    end else begin
      strobe.regVec = 1'b1;
      strobe.regTgt = regKeyWide << COMPACT_SHIFT;
    end
    // predicate entry
    strobe.predWr   = predLdValid;
    strobe.predIdx  = {predLdData[CLASS_BIT], predLdData[KEY_W-1:0]};
    strobe.predInv  = predLdData[INV_BIT];
    strobe.predZero = predLdData[ZERO_BIT];
    if (predLdWide) begin
      strobe.predNum = predLdData[TGT_LO +: PHYS_W];
      strobe.predFf  = predLdData[MODE_BIT];
    end else begin
      strobe.predNum = predKeyWide + PHYS_W'(PRED_BASE);
      strobe.predFf  = 1'b0;
    end
  end
endmodule

// File: rtl/svrTableDp.sv
module svrTableDp
  import svrPkg::*;
#(
  parameter int NUM_LK = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tblStrobeT                     strobe,
  input  logic [NUM_LK-1:0][KEY_W-1:0]  lkNum,
  input  logic [NUM_LK-1:0]             lkIsInt,
  output logic [NUM_LK-1:0]             laneAct,
  output logic [NUM_LK-1:0]             laneVec,
  output logic [NUM_LK-1:0][PHYS_W-1:0] laneReg,
  output logic [NUM_LK-1:0][EW_W-1:0]   laneEw,
  output logic                          predOnQ,
  output logic [PHYS_W-1:0]             predNumQ,
  output logic                          predInvQ,
  output logic                          predZeroQ,
  output logic                          predFfQ,
  output logic                          predAllQ
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RD_LANE = 0;

  // expanded tables, one slot per {class, number}
  logic [ENTRIES-1:0] regAct, regVec, predAct, predInv, predZero, predFf;
  logic [PHYS_W-1:0]  regTgt  [ENTRIES];
  logic [EW_W-1:0]    regEw   [ENTRIES];
  logic [PHYS_W-1:0]  predNum [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAct   <= '0;
      regVec   <= '0;
      predAct  <= '0;
      predInv  <= '0;
      predZero <= '0;
      predFf   <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        regTgt[e]  <= '0;
        regEw[e]   <= '0;
        predNum[e] <= '0;
      end
    end else begin
      if (strobe.regWr) begin
        regAct[strobe.regIdx] <= 1'b1;
        regVec[strobe.regIdx] <= strobe.regVec;
        regTgt[strobe.regIdx] <= strobe.regTgt;
        regEw[strobe.regIdx]  <= strobe.regEw;
      end
      if (strobe.predWr) begin
        predAct[strobe.predIdx]  <= 1'b1;
        predInv[strobe.predIdx]  <= strobe.predInv;
        predZero[strobe.predIdx] <= strobe.predZero;
        predFf[strobe.predIdx]   <= strobe.predFf;
        predNum[strobe.predIdx]  <= strobe.predNum;
      end
    end
  end

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.regWr)) |->
      (regAct[$past(strobe.regIdx)] && regTgt[$past(strobe.regIdx)] == $past(strobe.regTgt)))
    else $error("register load not visible next cycle"); // R11

  // operand lanes: one-hot select, AND-OR gather
  for (genvar g = 0; g < NUM_LK; g++) begin : gLane
    logic [IDX_W-1:0]  idx;
    logic [ENTRIES-1:0] sel;
    logic              hit, vecN;
    logic [PHYS_W-1:0] tgtN;
    logic [EW_W-1:0]   ewN;
    logic              actQ, vecQ;
    logic [PHYS_W-1:0] regQ;
    logic [EW_W-1:0]   ewQ;

    assign idx = {lkIsInt[g], lkNum[g]};

    always_comb begin
      sel  = '0;
      sel[idx] = 1'b1;
      hit  = 1'b0;
      vecN = 1'b0;
      tgtN = '0;
      ewN  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        hit  = hit  | (sel[e] & regAct[e]);
        vecN = vecN | (sel[e] & regAct[e] & regVec[e]);
        tgtN = tgtN | ({PHYS_W{sel[e] & regAct[e]}} & regTgt[e]);
        ewN  = ewN  | ({EW_W{sel[e] & regAct[e]}} & regEw[e]);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actQ <= 1'b0;
        vecQ <= 1'b0;
        regQ <= '0;
        ewQ  <= '0;
      end else begin
        actQ <= hit;
        vecQ <= vecN;
        regQ <= hit ? tgtN : PHYS_W'(lkNum[g]);
        ewQ  <= ewN;
      end
    end

    assign laneAct[g] = actQ;
    assign laneVec[g] = vecQ;
    assign laneReg[g] = regQ;
    assign laneEw[g]  = ewQ;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !actQ) |->
        (!vecQ && ewQ == '0 && regQ == PHYS_W'($past(lkNum[g]))))
      else $error("unmatched operand not passed through"); // R12
  end

  // predicate lookup keyed on the destination operand
  logic [IDX_W-1:0]   rdIdx;
  logic [ENTRIES-1:0] rdSel;
  logic               pHit, pInvN, pZeroN, pFfN;
  logic [PHYS_W-1:0]  pNumN;

  assign rdIdx = {lkIsInt[RD_LANE], lkNum[RD_LANE]};

  always_comb begin
    rdSel  = '0;
    rdSel[rdIdx] = 1'b1;
    pHit   = 1'b0;
    pInvN  = 1'b0;
    pZeroN = 1'b0;
    pFfN   = 1'b0;
    pNumN  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      pHit   = pHit   | (rdSel[e] & regAct[e] & predAct[e]);
      pInvN  = pInvN  | (rdSel[e] & regAct[e] & predAct[e] & predInv[e]);
      pZeroN = pZeroN | (rdSel[e] & regAct[e] & predAct[e] & predZero[e]);
      pFfN   = pFfN   | (rdSel[e] & regAct[e] & predAct[e] & predFf[e]);
      pNumN  = pNumN  | ({PHYS_W{rdSel[e] & regAct[e] & predAct[e]}} & predNum[e]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predOnQ   <= 1'b0;
      predNumQ  <= '0;
      predInvQ  <= 1'b0;
      predZeroQ <= 1'b0;
      predFfQ   <= 1'b0;
      predAllQ  <= 1'b0;
    end else begin
      predOnQ   <= pHit;
      predNumQ  <= pNumN;
      predInvQ  <= pInvN;
      predZeroQ <= pZeroN;
      predFfQ   <= pFfN;
      predAllQ  <= pHit & pInvN & (pNumN == '0);
    end
  end

  AST_PRED_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !laneAct[RD_LANE] |-> !predOnQ)
    else $error("predicate reported without register entry"); // R7

  AST_PRED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !predOnQ |-> (predNumQ == '0 && !predInvQ && !predZeroQ && !predFfQ && !predAllQ))
    else $error("predicate fields not cleared"); // R7

  AST_ALL_ONES_SRC: assert property (@(posedge clk) disable iff (!rstN)
    predAllQ |-> (predOnQ && predInvQ && predNumQ == '0))
    else $error("all-ones flag inconsistent"); // R9
endmodule

// File: rtl/svr_redirect_top.sv
module svr_redirect_top
  import svrPkg::*;
#(
  parameter int COMPACT_SHIFT = 2,
  parameter int PRED_BASE     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regLdValid,
  input  logic              regLdWide,
  input  logic [15:0]       regLdData,
  input  logic              predLdValid,
  input  logic              predLdWide,
  input  logic [15:0]       predLdData,
  input  logic [4:0]        rdNum,
  input  logic              rdIsInt,
  input  logic [4:0]        rs1Num,
  input  logic              rs1IsInt,
  input  logic [4:0]        rs2Num,
  input  logic              rs2IsInt,
  output logic              rdVec,
  output logic [6:0]        rdReg,
  output logic [1:0]        rdWidth,
  output logic              rs1Vec,
  output logic [6:0]        rs1Reg,
  output logic [1:0]        rs1Width,
  output logic              rs2Vec,
  output logic [6:0]        rs2Reg,
  output logic [1:0]        rs2Width,
  output logic              predOn,
  output logic [6:0]        predReg,
  output logic              predInv,
  output logic              predZero,
  output logic              predFfirst,
  output logic              predAllOnes
);
  localparam int NUM_LK = 3;

  tblStrobeT                     strobe;
  logic [NUM_LK-1:0][KEY_W-1:0]  lkNum;
  logic [NUM_LK-1:0]             lkIsInt;
  logic [NUM_LK-1:0]             laneAct;
  logic [NUM_LK-1:0]             laneVec;
  logic [NUM_LK-1:0][PHYS_W-1:0] laneReg;
  logic [NUM_LK-1:0][EW_W-1:0]   laneEw;

  assign lkNum   = {rs2Num, rs1Num, rdNum};
  assign lkIsInt = {rs2IsInt, rs1IsInt, rdIsInt};

  svrLoadCtl #(
    .COMPACT_SHIFT(COMPACT_SHIFT),
    .PRED_BASE    (PRED_BASE)
  ) uCtl (
    .regLdValid (regLdValid),
    .regLdWide  (regLdWide),
    .regLdData  (regLdData),
    .predLdValid(predLdValid),
    .predLdWide (predLdWide),
    .predLdData (predLdData),
    .strobe     (strobe)
  );

  svrTableDp #(.NUM_LK(NUM_LK)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lkNum    (lkNum),
    .lkIsInt  (lkIsInt),
    .laneAct  (laneAct),
    .laneVec  (laneVec),
    .laneReg  (laneReg),
    .laneEw   (laneEw),
    .predOnQ  (predOn),
    .predNumQ (predReg),
    .predInvQ (predInv),
    .predZeroQ(predZero),
    .predFfQ  (predFfirst),
    .predAllQ (predAllOnes)
  );

  assign rdVec    = laneVec[0];
  assign rdReg    = laneReg[0];
  assign rdWidth  = laneEw[0];
  assign rs1Vec   = laneVec[1];
  assign rs1Reg   = laneReg[1];
  assign rs1Width = laneEw[1];
  assign rs2Vec   = laneVec[2];
  assign rs2Reg   = laneReg[2];
  assign rs2Width = laneEw[2];

  AST_SCALAR_NO_LANE_ACT_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (!laneAct[1] && !laneAct[2]) |-> (!rs1Vec && !rs2Vec && rs1Width == 2'b00 && rs2Width == 2'b00))
    else $error("source lane reports vector without entry"); // R12
endmodule

// File: tb/sim_svr_redirect_top.sv
`timescale 1ns/1ps
module sim_svr_redirect_top;
  logic clk = 1'b0;
  logic rstN;
  logic regLdValid, regLdWide, predLdValid, predLdWide;
  logic [15:0] regLdData, predLdData;
  logic [4:0] rdNum, rs1Num, rs2Num;
  logic rdIsInt, rs1IsInt, rs2IsInt;
  logic rdVec, rs1Vec, rs2Vec;
  logic [6:0] rdReg, rs1Reg, rs2Reg, predReg;
  logic [1:0] rdWidth, rs1Width, rs2Width;
  logic predOn, predInv, predZero, predFfirst, predAllOnes;

  always #2 clk = ~clk;

  svr_redirect_top u0 (
    .clk(clk), .rstN(rstN),
    .regLdValid(regLdValid), .regLdWide(regLdWide), .regLdData(regLdData),
    .predLdValid(predLdValid), .predLdWide(predLdWide), .predLdData(predLdData),
    .rdNum(rdNum), .rdIsInt(rdIsInt), .rs1Num(rs1Num), .rs1IsInt(rs1IsInt),
    .rs2Num(rs2Num), .rs2IsInt(rs2IsInt),
    .rdVec(rdVec), .rdReg(rdReg), .rdWidth(rdWidth),
    .rs1Vec(rs1Vec), .rs1Reg(rs1Reg), .rs1Width(rs1Width),
    .rs2Vec(rs2Vec), .rs2Reg(rs2Reg), .rs2Width(rs2Width),
    .predOn(predOn), .predReg(predReg), .predInv(predInv), .predZero(predZero),
    .predFfirst(predFfirst), .predAllOnes(predAllOnes)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference tables, indexed by class*32 + number
  bit mAct [64];
  bit mVec [64];
  int mTgt [64];
  int mEw  [64];
  bit pAct [64];
  int pNum [64];
  bit pInv [64];
  bit pZer [64];
  bit pFf  [64];

  function automatic [15:0] fullReg(int key, bit isInt, int ew, int tgt, bit scalar);
    return {scalar, 7'(tgt), 2'(ew), isInt, 5'(key)};
  endfunction
  function automatic [15:0] compReg(int key, bit isInt, int ew);
    return {8'h00, 2'(ew), isInt, 5'(key)};
  endfunction
  function automatic [15:0] fullPred(int key, bit isInt, int num, bit inv, bit zer, bit ff);
    return {ff, 7'(num), zer, inv, isInt, 5'(key)};
  endfunction
  function automatic [15:0] compPred(int key, bit isInt, bit inv, bit zer);
    return {8'h00, zer, inv, isInt, 5'(key)};
  endfunction

  function automatic [9:0] expLane(int num, bit isInt);
    int s = (isInt ? 32 : 0) + num;
    if (mAct[s]) return {mVec[s], 7'(mTgt[s]), 2'(mEw[s])};
    return {1'b0, 7'(num), 2'b00};
  endfunction

  function automatic [11:0] expPred(int num, bit isInt);
    int s = (isInt ? 32 : 0) + num;
    if (mAct[s] && pAct[s])
      return {1'b1, 7'(pNum[s]), pInv[s], pZer[s], pFf[s], (pNum[s] == 0) && pInv[s]};
    return 12'h000;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, predict from pre-load model, compare next negedge
  task automatic step(string tag, bit rv, bit rw, logic [15:0] rdat,
                      bit pv, bit pw, logic [15:0] pdat,
                      int n0, bit i0, int n1, bit i1, int n2, bit i2);
    logic [9:0] e0, e1, e2;
    logic [11:0] ep;
    regLdValid = rv; regLdWide = rw; regLdData = rdat;
    predLdValid = pv; predLdWide = pw; predLdData = pdat;
    rdNum = 5'(n0); rdIsInt = i0; rs1Num = 5'(n1); rs1IsInt = i1; rs2Num = 5'(n2); rs2IsInt = i2;
    e0 = expLane(n0, i0); e1 = expLane(n1, i1); e2 = expLane(n2, i2);
    ep = expPred(n0, i0);
    if (rv) begin
      int s = (rdat[5] ? 32 : 0) + int'(rdat[4:0]);
      mAct[s] = 1; mEw[s] = int'(rdat[7:6]);
      if (rw) begin mVec[s] = !rdat[15]; mTgt[s] = int'(rdat[14:8]); end
      else begin mVec[s] = 1; mTgt[s] = int'(rdat[4:0]) * 4; end
    end
    if (pv) begin
      int s = (pdat[5] ? 32 : 0) + int'(pdat[4:0]);
      pAct[s] = 1; pInv[s] = pdat[6]; pZer[s] = pdat[7];
      if (pw) begin pNum[s] = int'(pdat[14:8]); pFf[s] = pdat[15]; end
      else begin pNum[s] = int'(pdat[4:0]) + 9; pFf[s] = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rd lane",  int'({rdVec, rdReg, rdWidth}), int'(e0));
    check(tag, "rs1 lane", int'({rs1Vec, rs1Reg, rs1Width}), int'(e1));
    check(tag, "rs2 lane", int'({rs2Vec, rs2Reg, rs2Width}), int'(e2));
    check(tag, "predicate", int'({predOn, predReg, predInv, predZero, predFfirst, predAllOnes}), int'(ep));
  endtask

  task automatic look(string tag, int n0, bit i0, int n1, bit i1, int n2, bit i2);
    step(tag, 0, 0, 16'h0, 0, 0, 16'h0, n0, i0, n1, i1, n2, i2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0;
    regLdValid = 0; regLdWide = 0; regLdData = '0;
    predLdValid = 0; predLdWide = 0; predLdData = '0;
    rdNum = 5'd3; rdIsInt = 1; rs1Num = 5'd17; rs1IsInt = 0; rs2Num = 5'd31; rs2IsInt = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared under reset
    check("R1", "reset outputs",
          int'({rdVec, rdReg, rdWidth, rs1Vec, rs1Reg, rs1Width, rs2Vec, rs2Reg, rs2Width,
                predOn, predReg, predInv, predZero, predFfirst, predAllOnes}), 0);
    rstN = 1'b1;
    // R12: empty table passes operands through
    look("R12", 3, 1, 17, 0, 31, 1);
    look("R12", 0, 0, 30, 1, 12, 0);

    // R3: full entries, vector and forced scalar, both classes on key 5
    step("R3", 1, 1, fullReg(5, 1, 2, 100, 0), 0, 0, 16'h0, 5, 1, 5, 0, 6, 1);
    step("R3", 1, 1, fullReg(5, 0, 3, 77, 1), 0, 0, 16'h0, 5, 1, 5, 0, 5, 1);
    // R2: class bit must agree as well as the key
    look("R2", 5, 0, 5, 1, 6, 0);
    // R4: compact entries imply key*4 and vector
    step("R4", 1, 0, compReg(7, 1, 1), 0, 0, 16'h0, 7, 1, 7, 0, 5, 1);
    step("R4", 1, 0, compReg(31, 0, 0), 0, 0, 16'h0, 7, 1, 31, 0, 31, 1);
    look("R4", 31, 0, 7, 1, 7, 0);
    // R5: width codes 01, 10, 11 from different entries
    look("R5", 7, 1, 5, 1, 5, 0);

    // R6: full predicate on int key 5
    step("R6", 0, 0, 16'h0, 1, 1, fullPred(5, 1, 45, 1, 0, 1), 5, 1, 0, 0, 0, 0);
    look("R6", 5, 1, 5, 1, 7, 1);
    // R7: predicate without register entry is never reported
    step("R7", 0, 0, 16'h0, 1, 1, fullPred(9, 1, 60, 1, 1, 1), 9, 1, 9, 1, 9, 0);
    look("R7", 9, 1, 5, 1, 9, 0);
    look("R7", 5, 0, 5, 1, 5, 1);
    // R8: compact predicate implies key+9, no fail-on-first
    step("R8", 0, 0, 16'h0, 1, 0, compPred(5, 0, 0, 1), 5, 0, 5, 1, 5, 0);
    look("R8", 5, 0, 1, 1, 2, 0);
    // R9: register 0 with invert gives all-ones; without invert it does not
    step("R9", 0, 0, 16'h0, 1, 1, fullPred(7, 1, 0, 1, 0, 1), 7, 1, 0, 0, 0, 0);
    look("R9", 7, 1, 7, 0, 31, 0);
    step("R9", 0, 0, 16'h0, 1, 1, fullPred(7, 1, 0, 0, 1, 1), 7, 1, 7, 1, 7, 1);
    look("R9", 7, 1, 7, 1, 7, 1);
    // R10: load and lookup of the same key in one cycle sees the old table
    step("R10", 1, 1, fullReg(12, 1, 1, 99, 0), 0, 0, 16'h0, 12, 1, 12, 1, 12, 0);
    look("R10", 12, 1, 12, 1, 12, 0);
    step("R10", 1, 0, compReg(12, 0, 2), 1, 1, fullPred(12, 0, 3, 0, 1, 0), 12, 0, 12, 0, 12, 1);
    look("R10", 12, 0, 12, 1, 12, 0);
    // R11: reloading replaces the previous entry
    step("R11", 1, 0, compReg(5, 1, 0), 1, 0, compPred(5, 1, 1, 1), 5, 1, 5, 1, 5, 0);
    look("R11", 5, 1, 5, 1, 5, 0);

    // mixed traffic on a narrow key range so loads and lookups collide
    for (int k = 0; k < 600; k++) begin
      bit rv = ($urandom_range(0, 3) == 0);
      bit pv = ($urandom_range(0, 3) == 0);
      logic [15:0] rd16 = 16'($urandom);
      logic [15:0] pd16 = 16'($urandom);
      rd16[4:0] = 5'($urandom_range(0, 7));
      pd16[4:0] = 5'($urandom_range(0, 7));
      step("R10", rv, 1'($urandom), rd16, pv, 1'($urandom), pd16,
           $urandom_range(0, 7), 1'($urandom), $urandom_range(0, 7), 1'($urandom),
           $urandom_range(0, 9), 1'($urandom));
    end
    summary();
  end
endmodule